// File: doc/BRIEF.md
# Four-by-Four Word Transpose Unit

This unit receives four 64-bit source operands in one request and treats them as a 4×4 matrix of 16-bit words. Each source is one row of the matrix. The unit returns half of the transposed matrix as two 64-bit results, which are written to an even/odd destination register pair. A select input picks the half. The upper variant returns transposed rows 0 and 1. The lower variant returns transposed rows 2 and 3. Software issues both variants to get the full transpose.

The unit also checks the register numbers of each request. The sources must be four consecutive registers that start on a multiple of four. The destination pair must start on an even register. A request that breaks either rule produces no result. It raises an illegal-operand flag instead. Results are registered and appear one clock after the request. The results and the destination number hold their values until the next legal request.

Top module: `wt_transpose_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `resValid` and `illegalOperand` are 0, and `resFirst`, `resSecond` and `resDst` are 0.
- R2: Source k sits in `srcMat[k*64 +: 64]`. Word 0 of a source is its most significant 16 bits. Transposed row r is made of word r of source 0 (in bits 63:48), then word r of source 1, source 2 and source 3 (in bits 15:0).
- R3: A legal request with `selHigh`=1 sets `resFirst` to transposed row 0 and `resSecond` to transposed row 1.
- R4: A legal request with `selHigh`=0 sets `resFirst` to transposed row 2 and `resSecond` to transposed row 3.
- R5: A request whose `srcBase` is not a multiple of 4 sets `illegalOperand` to 1 and `resValid` to 0 in the next cycle.
- R6: A request whose `dstBase` is odd sets `illegalOperand` to 1 and `resValid` to 0 in the next cycle.
- R7: A legal request sets `resValid` to 1 for exactly the next cycle, and sets `resDst` to its `dstBase`.
- R8: `resFirst`, `resSecond` and `resDst` keep their values in every cycle that does not follow a legal request. This includes cycles that follow an illegal request.
- R9: A cycle that follows one with `reqValid`=0 has `resValid`=0 and `illegalOperand`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| selHigh | input | 1 | 1 selects transposed rows 0/1; 0 selects rows 2/3 |
| srcBase | input | 3 | Number of the first source register |
| dstBase | input | 3 | Number of the first destination register |
| srcMat | input | 256 | The four sources; source k is in bits k*64+63 down to k*64 |
| resValid | output | 1 | Result pair is new this cycle |
| illegalOperand | output | 1 | The previous request broke a register-number rule |
| resDst | output | 3 | Destination pair number of the current result |
| resFirst | output | 64 | Result for the even destination register |
| resSecond | output | 64 | Result for the odd destination register |

## Verification
Every output of this block is due in the cycle after the request that caused it. This applies to the flag pulse and the result pair alike. The driver tags each expected item with the cycle count at the clock edge that captures the request. The monitor pops an item only at the falling edge inside that cycle. Idle cycles and illegal cycles also produce expected items. These items carry the previous result pair, so the hold rule is checked in every cycle and not only when results are produced.

// File: rtl/wt_pkg.sv
package wt_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic capture;   // legal request: load the result pair
    logic pickHigh;  // choose transposed rows 0/1 rather than 2/3
  } wtStrobes_t;
endpackage

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int REG_IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic                 selHigh,
  input  logic [REG_IDX_W-1:0] srcBase,
  input  logic [REG_IDX_W-1:0] dstBase,
  output wtStrobes_t           strobes,
  output logic                 resValid,
  output logic                 illegalOperand,
  output logic [REG_IDX_W-1:0] resDst
);
  localparam int ALIGN_W = $clog2(LANES);

  logic srcAligned;
  logic dstEven;
  logic legalReq;

  always_comb begin
    srcAligned       = (srcBase[ALIGN_W-1:0] == '0);
    dstEven          = ~dstBase[0];
    legalReq         = srcAligned & dstEven;
    strobes.capture  = reqValid & legalReq;
    strobes.pickHigh = selHigh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid       <= 1'b0;
      illegalOperand <= 1'b0;
      resDst         <= '0;
    end else begin
      resValid       <= strobes.capture;
      illegalOperand <= reqValid & ~legalReq;
      if (strobes.capture) resDst <= dstBase;
    end
  end
endmodule

// File: rtl/wt_datapath.sv
module wt_datapath
  import wt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANES  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  wtStrobes_t                    strobes,
  input  logic [LANES*LANES*WORD_W-1:0] srcMat,
  output logic [LANES*WORD_W-1:0]       resFirst,
  output logic [LANES*WORD_W-1:0]       resSecond
);
  localparam int ROW_W    = LANES * WORD_W;
  localparam int HALF     = LANES / 2;
  localparam int ROW_IDXW = $clog2(LANES);

  logic [ROW_W-1:0] rowsT [LANES];
  logic [ROW_IDXW-1:0] baseRow;
  logic [ROW_W-1:0] nextFirst;
  logic [ROW_W-1:0] nextSecond;

  // Row r gathers word r of every source, source 0 in the top word
  for (genvar r = 0; r < LANES; r++) begin : g_row
    for (genvar k = 0; k < LANES; k++) begin : g_src
      assign rowsT[r][(LANES-1-k)*WORD_W +: WORD_W] =
        srcMat[k*ROW_W + (LANES-1-r)*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    baseRow    = strobes.pickHigh ? ROW_IDXW'(0) : ROW_IDXW'(HALF);
    nextFirst  = rowsT[baseRow];
    nextSecond = rowsT[baseRow + ROW_IDXW'(1)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resFirst  <= '0;
      resSecond <= '0;
    end else if (strobes.capture) begin
      resFirst  <= nextFirst;
      resSecond <= nextSecond;
    end
  end
endmodule

// File: rtl/wt_transpose_unit.sv
module wt_transpose_unit
  import wt_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int LANES     = 4,
  parameter int REG_IDX_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  input  logic                          selHigh,
  input  logic [REG_IDX_W-1:0]          srcBase,
  input  logic [REG_IDX_W-1:0]          dstBase,
  input  logic [LANES*LANES*WORD_W-1:0] srcMat,
  output logic                          resValid,
  output logic                          illegalOperand,
  output logic [REG_IDX_W-1:0]          resDst,
  output logic [LANES*WORD_W-1:0]       resFirst,
  output logic [LANES*WORD_W-1:0]       resSecond
);
  wtStrobes_t strobes;

  wt_ctrl #(.LANES(LANES), .REG_IDX_W(REG_IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .selHigh(selHigh),
    .srcBase(srcBase), .dstBase(dstBase), .strobes(strobes),
    .resValid(resValid), .illegalOperand(illegalOperand), .resDst(resDst)
  );

  wt_datapath #(.WORD_W(WORD_W), .LANES(LANES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .srcMat(srcMat),
    .resFirst(resFirst), .resSecond(resSecond)
  );
endmodule

// File: rtl/wt_transpose_checker.sv
module wt_transpose_checker #(
  parameter int WORD_W    = 16,
  parameter int LANES     = 4,
  parameter int REG_IDX_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reqValid,
  input logic                          selHigh,
  input logic [REG_IDX_W-1:0]          srcBase,
  input logic [REG_IDX_W-1:0]          dstBase,
  input logic [LANES*LANES*WORD_W-1:0] srcMat,
  input logic                          resValid,
  input logic                          illegalOperand,
  input logic [REG_IDX_W-1:0]          resDst,
  input logic [LANES*WORD_W-1:0]       resFirst,
  input logic [LANES*WORD_W-1:0]       resSecond
);
  localparam int ROW_W   = LANES * WORD_W;
  localparam int ALIGN_W = $clog2(LANES);

  logic srcBad;
  logic dstBad;
  assign srcBad = (srcBase[ALIGN_W-1:0] != '0);
  assign dstBad = dstBase[0];

  // R5: misaligned source base flags and withholds the result
  assert_src_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && srcBad) |=> (illegalOperand && !resValid));

  // R6: odd destination base flags and withholds the result
  assert_dst_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && dstBad) |=> (illegalOperand && !resValid));

  // R7: legal request yields a valid result with its destination
  assert_legal_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !srcBad && !dstBad) |=>
      (resValid && !illegalOperand && resDst == $past(dstBase)));

  // R9: no request, no flags next cycle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!resValid && !illegalOperand));

  // R8: results only move in a valid cycle
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !resValid |-> ($stable(resFirst) && $stable(resSecond) && $stable(resDst)));

  // R3: upper variant puts source 0 word 0 at the top of the first result
  assert_high_row0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !srcBad && !dstBad && selHigh) |=>
      (resFirst[ROW_W-1 -: WORD_W] == $past(srcMat[ROW_W-1 -: WORD_W])));

  // R4: lower variant puts source 0 word LANES/2 at the top of the first result
  assert_low_row2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !srcBad && !dstBad && !selHigh) |=>
      (resFirst[ROW_W-1 -: WORD_W] ==
       $past(srcMat[(LANES/2)*WORD_W-1 -: WORD_W])));
endmodule

bind wt_transpose_unit wt_transpose_checker #(
  .WORD_W(WORD_W), .LANES(LANES), .REG_IDX_W(REG_IDX_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .selHigh(selHigh),
  .srcBase(srcBase), .dstBase(dstBase), .srcMat(srcMat),
  .resValid(resValid), .illegalOperand(illegalOperand), .resDst(resDst),
  .resFirst(resFirst), .resSecond(resSecond)
);

// File: tb/wt_transpose_unit_tb.sv
module wt_transpose_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reqValid = 1'b0;
  logic         selHigh = 1'b0;
  logic [2:0]   srcBase = '0;
  logic [2:0]   dstBase = '0;
  logic [255:0] srcMat = '0;
  logic         resValid;
  logic         illegalOperand;
  logic [2:0]   resDst;
  logic [63:0]  resFirst;
  logic [63:0]  resSecond;

  int checks = 0;
  int fails  = 0;
  int cycleCount = 0;
  logic watchdogHit = 1'b0;
  logic monitorOn = 1'b0;

  typedef struct {
    int          due;
    logic        valid;
    logic        illegal;
    logic [2:0]  dst;
    logic [63:0] first;
    logic [63:0] second;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [63:0] keepFirst  = '0;
  logic [63:0] keepSecond = '0;
  logic [2:0]  keepDst    = '0;

  wt_transpose_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .selHigh(selHigh),
    .srcBase(srcBase), .dstBase(dstBase), .srcMat(srcMat),
    .resValid(resValid), .illegalOperand(illegalOperand), .resDst(resDst),
    .resFirst(resFirst), .resSecond(resSecond)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cycleCount <= cycleCount + 1;

  // Word w of a source, word 0 most significant (R2)
  function automatic logic [15:0] wordOf(logic [63:0] s, int w);
    return s[63-16*w -: 16];
  endfunction

  function automatic logic [63:0] tRow(logic [63:0] s0, logic [63:0] s1,
                                       logic [63:0] s2, logic [63:0] s3, int r);
    return {wordOf(s0, r), wordOf(s1, r), wordOf(s2, r), wordOf(s3, r)};
  endfunction

  // Drive one cycle of stimulus and push what is due a cycle later
  task automatic drive(input logic req, input logic hi, input logic [2:0] sb,
                       input logic [2:0] db, input logic [63:0] s0,
                       input logic [63:0] s1, input logic [63:0] s2,
                       input logic [63:0] s3, input string tag);
    expItem_t e;
    logic legal;
    @(posedge clk);
    #2;
    reqValid = req; selHigh = hi; srcBase = sb; dstBase = db;
    srcMat = {s3, s2, s1, s0};
    legal = (sb[1:0] == 2'b00) && !db[0];
    e.due = cycleCount + 1;
    e.valid = req && legal;
    e.illegal = req && !legal;
    if (req && legal) begin
      keepFirst  = hi ? tRow(s0, s1, s2, s3, 0) : tRow(s0, s1, s2, s3, 2);
      keepSecond = hi ? tRow(s0, s1, s2, s3, 1) : tRow(s0, s1, s2, s3, 3);
      keepDst    = db;
    end
    e.first = keepFirst; e.second = keepSecond; e.dst = keepDst;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 3'd0, 3'd0, 64'h0, 64'h0, 64'h0, 64'h0, tag);
  endtask

  always @(negedge clk) begin
    if (monitorOn) begin
      while (expQ.size() > 0 && expQ[0].due == cycleCount) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (resValid !== e.valid || illegalOperand !== e.illegal ||
            resDst !== e.dst || resFirst !== e.first || resSecond !== e.second) begin
          fails++;
          $display("FAIL %s: got v=%b ill=%b dst=%0d first=%h second=%h exp v=%b ill=%b dst=%0d first=%h second=%h",
                   e.tag, resValid, illegalOperand, resDst, resFirst, resSecond,
                   e.valid, e.illegal, e.dst, e.first, e.second);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    watchdogHit = 1'b1;
  end

  initial begin
    logic [63:0] a, b, c, d;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || illegalOperand !== 1'b0 || resDst !== 3'd0 ||
        resFirst !== 64'h0 || resSecond !== 64'h0) begin
      fails++;
      $display("FAIL R1: got v=%b ill=%b dst=%0d first=%h second=%h exp all zero",
               resValid, illegalOperand, resDst, resFirst, resSecond);
    end
    rst_n = 1'b1;
    monitorOn = 1'b1;
    idle("R1 first cycle after reset");
    idle("R9 idle");

    // R2/R3: upper variant, distinct word values
    drive(1'b1, 1'b1, 3'd0, 3'd2, 64'h0001_0002_0003_0004, 64'h0101_0102_0103_0104,
          64'h0201_0202_0203_0204, 64'h0301_0302_0303_0304, "R3 R2 high rows 0/1");
    // R4: lower variant, same data, back-to-back
    drive(1'b1, 1'b0, 3'd4, 3'd6, 64'h0001_0002_0003_0004, 64'h0101_0102_0103_0104,
          64'h0201_0202_0203_0204, 64'h0301_0302_0303_0304, "R4 R2 low rows 2/3");
    idle("R8 R9 hold after low");
    // R5: each misaligned source base, hold must persist
    for (int sb = 1; sb < 8; sb++) begin
      if (sb % 4 != 0)
        drive(1'b1, sb[0], sb[2:0], 3'd0, 64'hFFFF_EEEE_DDDD_CCCC, 64'h1, 64'h2, 64'h3,
              "R5 R8 misaligned source");
    end
    // R6: odd destination bases
    for (int db = 1; db < 8; db += 2)
      drive(1'b1, 1'b1, 3'd4, db[2:0], 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h0, 64'h0,
            "R6 R8 odd destination");
    drive(1'b1, 1'b0, 3'd3, 3'd5, 64'hAAAA, 64'hBBBB, 64'hCCCC, 64'hDDDD,
          "R5 R6 both rules broken");
    // R7: legal after illegal, destination updates
    drive(1'b1, 1'b1, 3'd4, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_0000_FFFF_0000,
          64'h0000_FFFF_0000_FFFF, "R7 R3 legal after illegal");
    idle("R7 single-cycle pulse");
    idle("R9 idle again");
    // Random patterns, alternating variants with gaps
    for (int i = 0; i < 40; i++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      c = {$urandom, $urandom}; d = {$urandom, $urandom};
      drive(1'b1, i[0], (i % 3 == 0) ? 3'd4 : 3'd0, 3'(2 * (i % 4)), a, b, c, d,
            i[0] ? "R3 R2 random high" : "R4 R2 random low");
      if (i % 5 == 0) idle("R8 random hold");
    end
    idle("R9 drain");
    idle("R9 drain");
    repeat (2) @(posedge clk);
    finish();
  end

  task automatic finish();
    @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R7: %0d expected results never compared, expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge watchdogHit) begin
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cycleCount);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule